// File: doc/BRIEF.md
# Multi-mode transmit FIFO for a transceiver PCS

This block buffers transmit words on their way from fabric logic into the serializer-side PCS datapath. Each word is 64 data bits plus a small control field (2 bits for 66-bit framing, 3 bits for 67-bit framing) that marks block boundaries. The control field travels with its data word unchanged.

A static two-bit mode input picks the behaviour, and it may change only while reset is held. In phase-compensation mode every cycle writes a word, whatever the write strobe says. In bypass mode no storage is used, and the write word and its valid strobe pass through one output register. In elastic mode a word is written only when the strobe is high, and the read side drains at its own pace. A static double-width input makes every write carry two words in one entry, so the fabric side can run at half the word rate. The read side then sends the two words out one at a time, lower word first.

The buffer holds sixteen entries. It reports exact empty and full flags and a partially-full flag with a configurable threshold. It also has sticky flags for writes dropped while full and reads refused while empty.

Top module: `txq_multimode_fifo`

## Requirements
- R1: While reset is high on a clock edge, the edge clears everything. After it, empty_o=1, full_o=0, pfull_o=0, ovf_o=0, udf_o=0, rd_valid_o=0, and rd_data_o and rd_ctrl_o are zero.
- R2: When mode_i=2'b00 (phase compensation), every clock edge outside reset attempts a write of the lower word, and wr_valid_i has no effect.
- R3: When mode_i is 2'b10 or 2'b11 (elastic), an edge writes only when wr_valid_i=1. With wr_valid_i=0 the contents and the flags do not change unless a read takes place.
- R4: In the buffered modes, an edge with rd_en_i=1 and a non-empty buffer loads the oldest word into rd_data_o/rd_ctrl_o and sets rd_valid_o=1 for one cycle. Words leave in the order they were written.
- R5: When mode_i=2'b01 (bypass), each edge copies the lower word of wr_data_i, the lower field of wr_ctrl_i, and wr_valid_i to rd_data_o, rd_ctrl_o and rd_valid_o. rd_en_i is ignored, and empty_o=1, full_o=0, pfull_o=0 throughout.
- R6: full_o is 1 exactly when 16 entries are held. A write attempt while full is dropped, even when a read happens on the same edge, and it sets ovf_o. ovf_o stays set until reset.
- R7: A read attempt while empty leaves rd_data_o and rd_ctrl_o unchanged, drives rd_valid_o=0 on the next cycle, and sets udf_o. udf_o stays set until reset.
- R8: pfull_o is 1 exactly when the entry count is at or above PFULL_THR. PFULL_THR is chosen from 10, 11, 12 and 13.
- R9: When dbl_i=1, one write stores wr_data_i[63:0] with wr_ctrl_i[CW-1:0] and wr_data_i[127:64] with wr_ctrl_i[2*CW-1:CW] as a single entry. Reads emit the lower word and then the upper word. The entry is freed after its upper word has been read, and the flags count entries.
- R10: The control field read out is always the one written with the same data word, for CTRL_W of 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 phase compensation, 01 bypass, 10/11 elastic; static outside reset |
| dbl_i | input | 1 | Double-width packing, static outside reset |
| wr_data_i | input | 2*DATA_W | Write data; the upper word is used only in double-width mode |
| wr_ctrl_i | input | 2*CTRL_W | Write control fields, lower field paired with lower word |
| wr_valid_i | input | 1 | Write strobe (elastic write gate, bypass valid) |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered read data |
| rd_ctrl_o | output | CTRL_W | Registered read control field |
| rd_valid_o | output | 1 | Registered read-data valid |
| empty_o | output | 1 | No entries held |
| full_o | output | 1 | All 16 entries held |
| pfull_o | output | 1 | Entry count at or above the threshold |
| ovf_o | output | 1 | Sticky: a write was dropped while full |
| udf_o | output | 1 | Sticky: a read was refused while empty |

## Verification
A pointer that slips by one entry shows up at the flags on the very next edge: empty, full or the threshold flag changes one cycle early or late. It then shows up in the data at the next read, as a repeated or skipped word. A wrong half-select in double-width mode swaps or repeats words on the first read of an entry. A flag that is not sticky clears one cycle after it was set. The bench runs a queue model alongside the design and compares every output on every cycle, so each of these faults is reported within one or two cycles of its cause.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    TXQ_PHASE   = 2'b00,
    TXQ_BYPASS  = 2'b01,
    TXQ_ELASTIC = 2'b10,
    TXQ_ELAST_B = 2'b11
  } txq_mode_e;
endpackage

// File: rtl/txq_ptr_ctrl.sv
module txq_ptr_ctrl #(
  parameter int DEPTH     = 16,
  parameter int PFULL_THR = 12,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbl,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_half,
  output logic              empty,
  output logic              full,
  output logic              pfull,
  output logic              ovf,
  output logic              udf
);
  logic [CNT_W-1:0] wptr, rptr, count;
  logic             pop;

  assign count   = wptr - rptr;
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign pfull   = (count >= CNT_W'(PFULL_THR));
  assign wr_ok   = wr_req && !full;
  assign rd_ok   = rd_req && !empty;
  assign pop     = rd_ok && (!dbl || rd_half);
  assign wr_addr = wptr[ADDR_W-1:0];
  assign rd_addr = rptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_half <= 1'b0;
      ovf     <= 1'b0;
      udf     <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (pop)   rptr <= rptr + 1'b1;
      if (rd_ok) rd_half <= dbl ? !rd_half : 1'b0;
      if (wr_req && full)  ovf <= 1'b1;
      if (rd_req && empty) udf <= 1'b1;
    end
  end

  // R6: the two end flags never coincide, and the count never passes the depth
  assert_flag_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(full && empty) && (count <= CNT_W'(DEPTH)));
  // R6: without a read, a full buffer stays full (a blocked write cannot spill)
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    full && !rd_ok |=> full);
  // R6: the overflow flag is sticky
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R7: without a write, an empty buffer stays empty
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    empty && !wr_ok |=> empty);
  // R7: the underflow flag is sticky
  assert_udf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    udf |=> udf);
  // R8: the threshold lies below the depth, so full implies partially full
  assert_pfull_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    full |-> pfull);
  // R9: without double width the half select never leaves the lower word
  assert_half_single_R9: assert property (@(posedge clk) disable iff (rst)
    !dbl |=> !rd_half);
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int WORD_W  = 66,
  parameter int DEPTH   = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int ENT_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              rhalf,
  output logic [WORD_W-1:0] rword
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] ent;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ent   = mem[raddr];
  assign rword = rhalf ? ent[ENT_W-1:WORD_W] : ent[WORD_W-1:0];
endmodule

// File: rtl/txq_out_stage.sv
module txq_out_stage #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic [DATA_W-1:0] byp_data,
  input  logic [CTRL_W-1:0] byp_ctrl,
  input  logic              byp_valid,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [CTRL_W-1:0] mem_ctrl,
  output logic [DATA_W-1:0] data_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ctrl_q  <= '0;
      valid_q <= 1'b0;
    end else if (bypass) begin
      data_q  <= byp_data;
      ctrl_q  <= byp_ctrl;
      valid_q <= byp_valid;
    end else begin
      valid_q <= rd_ok;
      if (rd_ok) begin
        data_q <= mem_data;
        ctrl_q <= mem_ctrl;
      end
    end
  end

  // R7: with no accepted read, buffered modes hold the last word and drop valid
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !bypass && !rd_ok |=> !valid_q && $stable(data_q) && $stable(ctrl_q));
  // R5: in bypass the write word appears one cycle later
  assert_bypass_latency_R5: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (data_q == $past(byp_data)) && (valid_q == $past(byp_valid)));
endmodule

// File: rtl/txq_multimode_fifo.sv
module txq_multimode_fifo
  import txq_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CTRL_W    = 2,
  parameter int DEPTH     = 16,
  parameter int PFULL_THR = 12,
  localparam int WORD_W   = DATA_W + CTRL_W,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int LANES    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode_i,
  input  logic                     dbl_i,
  input  logic [LANES*DATA_W-1:0]  wr_data_i,
  input  logic [LANES*CTRL_W-1:0]  wr_ctrl_i,
  input  logic                     wr_valid_i,
  input  logic                     rd_en_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [CTRL_W-1:0]        rd_ctrl_o,
  output logic                     rd_valid_o,
  output logic                     empty_o,
  output logic                     full_o,
  output logic                     pfull_o,
  output logic                     ovf_o,
  output logic                     udf_o
);
  txq_mode_e mode;
  logic bypass, wr_req, rd_req, wr_ok, rd_ok, rd_half;
  logic [ADDR_W-1:0]       wr_addr, rd_addr;
  logic [LANES*WORD_W-1:0] wr_entry;
  logic [WORD_W-1:0]       rd_word;

  assign mode   = txq_mode_e'(mode_i);
  assign bypass = (mode == TXQ_BYPASS);
  assign wr_req = !bypass && ((mode == TXQ_PHASE) || wr_valid_i);
  assign rd_req = !bypass && rd_en_i;

  // Each lane pairs a data word with its own control field
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_entry[g*WORD_W +: WORD_W] =
      {wr_ctrl_i[g*CTRL_W +: CTRL_W], wr_data_i[g*DATA_W +: DATA_W]};
  end

  txq_ptr_ctrl #(.DEPTH(DEPTH), .PFULL_THR(PFULL_THR)) u_ptr (
    .clk(clk), .rst(rst), .dbl(dbl_i), .wr_req(wr_req), .rd_req(rd_req),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .rd_half(rd_half), .empty(empty_o), .full(full_o), .pfull(pfull_o),
    .ovf(ovf_o), .udf(udf_o)
  );

  txq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_ok), .waddr(wr_addr), .wdata(wr_entry),
    .raddr(rd_addr), .rhalf(rd_half), .rword(rd_word)
  );

  txq_out_stage #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_out (
    .clk(clk), .rst(rst), .bypass(bypass),
    .byp_data(wr_data_i[DATA_W-1:0]), .byp_ctrl(wr_ctrl_i[CTRL_W-1:0]),
    .byp_valid(wr_valid_i), .rd_ok(rd_ok),
    .mem_data(rd_word[DATA_W-1:0]), .mem_ctrl(rd_word[WORD_W-1:DATA_W]),
    .data_q(rd_data_o), .ctrl_q(rd_ctrl_o), .valid_q(rd_valid_o)
  );

  // R5: bypass never touches the buffer, so its flags sit at rest
  assert_bypass_flags_R5: assert property (@(posedge clk) disable iff (rst)
    bypass |-> empty_o && !full_o && !pfull_o);
  // R4: read data is only reported as valid after an accepted read
  assert_valid_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    !bypass && rd_valid_o |-> $past(rd_en_i) && !$past(empty_o));
endmodule

// File: tb/txq_multimode_fifo_tb.sv
`timescale 1ns/1ps
module txq_multimode_fifo_tb_top;
  localparam int DW = 64;
  localparam int CW = 2;
  localparam int DEPTH = 16;
  localparam int THR = 11;
  localparam int WW = DW + CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic dbl_i = 1'b0;
  logic [2*DW-1:0] wr_data_i = '0;
  logic [2*CW-1:0] wr_ctrl_i = '0;
  logic wr_valid_i = 1'b0;
  logic rd_en_i = 1'b0;
  logic [DW-1:0] rd_data_o;
  logic [CW-1:0] rd_ctrl_o;
  logic rd_valid_o, empty_o, full_o, pfull_o, ovf_o, udf_o;

  always #2.5 clk = ~clk;

  txq_multimode_fifo #(.DATA_W(DW), .CTRL_W(CW), .DEPTH(DEPTH), .PFULL_THR(THR)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .dbl_i(dbl_i),
    .wr_data_i(wr_data_i), .wr_ctrl_i(wr_ctrl_i), .wr_valid_i(wr_valid_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_ctrl_o(rd_ctrl_o),
    .rd_valid_o(rd_valid_o), .empty_o(empty_o), .full_o(full_o),
    .pfull_o(pfull_o), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  // Behavioural model: a queue of entries, each entry a pair of words
  logic [2*WW-1:0] m_q[$];
  bit m_half;
  logic [DW-1:0] m_data;
  logic [CW-1:0] m_ctrl;
  bit m_valid, m_ovf, m_udf;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int seq = 0;

  task automatic model_step();
    if (rst) begin
      m_q.delete(); m_half = 0; m_data = '0; m_ctrl = '0;
      m_valid = 0; m_ovf = 0; m_udf = 0;
    end else if (mode_i == 2'b01) begin
      m_data = wr_data_i[DW-1:0];
      m_ctrl = wr_ctrl_i[CW-1:0];
      m_valid = wr_valid_i;
    end else begin
      bit was_full, was_empty, wreq;
      logic [2*WW-1:0] ent;
      logic [WW-1:0] w;
      was_full = (m_q.size() == DEPTH);
      was_empty = (m_q.size() == 0);
      wreq = (mode_i == 2'b00) || wr_valid_i;
      m_valid = 0;
      if (rd_en_i) begin
        if (was_empty) m_udf = 1;
        else begin
          ent = m_q[0];
          w = (dbl_i && m_half) ? ent[2*WW-1:WW] : ent[WW-1:0];
          m_data = w[DW-1:0];
          m_ctrl = w[WW-1:DW];
          m_valid = 1;
          if (!dbl_i || m_half) void'(m_q.pop_front());
          m_half = dbl_i ? !m_half : 1'b0;
        end
      end
      if (wreq) begin
        if (was_full) m_ovf = 1;
        else m_q.push_back({wr_ctrl_i[2*CW-1:CW], wr_data_i[2*DW-1:DW],
                            wr_ctrl_i[CW-1:0], wr_data_i[DW-1:0]});
      end
    end
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e;
    e = (m_q.size() == 0);
    chk("rd_data", 64'(rd_data_o), 64'(m_data));
    chk("rd_ctrl", 64'(rd_ctrl_o), 64'(m_ctrl));
    chk("rd_valid", 64'(rd_valid_o), 64'(m_valid));
    chk("empty", 64'(empty_o), 64'(e));
    chk("full", 64'(full_o), 64'(m_q.size() == DEPTH));
    chk("pfull", 64'(pfull_o), 64'(m_q.size() >= THR));
    chk("ovf", 64'(ovf_o), 64'(m_ovf));
    chk("udf", 64'(udf_o), 64'(m_udf));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare();
  endtask

  // New write words on every call so order and pairing errors are visible
  task automatic new_words();
    seq++;
    wr_data_i = {32'h5A00_0000 + 32'(seq), 32'(seq) * 32'h9E37_79B1,
                 32'hC300_0000 ^ 32'(seq), ~(32'(seq) * 32'h0101_0101)};
    wr_ctrl_i = 4'(seq * 7);
  endtask

  task automatic reset_to(logic [1:0] m, logic d);
    rst = 1'b1; mode_i = m; dbl_i = d; wr_valid_i = 0; rd_en_i = 0;
    cur_req = "R1";
    tick(); tick();
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    reset_to(2'b00, 1'b0);
    cur_req = "R1"; chk("reset empty", 64'(empty_o), 64'd1);
    chk("reset valid", 64'(rd_valid_o), 64'd0);

    // R2: phase compensation writes each cycle with the strobe held low
    cur_req = "R2 R4 R10";
    for (int i = 0; i < 30; i++) begin
      new_words(); wr_valid_i = 0; rd_en_i = (i > 4) && (i % 3 != 0);
      tick();
    end
    // R6 R8: stop reading until full, then keep writing into a full buffer
    cur_req = "R6 R8";
    for (int i = 0; i < 20; i++) begin
      new_words(); rd_en_i = 0; tick();
    end
    chk("full after fill R6", 64'(full_o), 64'd1);
    chk("ovf sticky R6", 64'(ovf_o), 64'd1);

    // R3: elastic, strobe-gated writes against an independent read pattern
    reset_to(2'b10, 1'b0);
    cur_req = "R3 R4 R8 R10";
    for (int i = 0; i < 60; i++) begin
      new_words(); wr_valid_i = (i % 4 != 1); rd_en_i = (i % 5 < 2);
      tick();
    end
    // R3: strobe low, no reads: nothing may change
    cur_req = "R3";
    for (int i = 0; i < 5; i++) begin
      new_words(); wr_valid_i = 0; rd_en_i = 0; tick();
    end
    // R7: drain past empty
    cur_req = "R7 R4";
    for (int i = 0; i < 30; i++) begin
      new_words(); wr_valid_i = 0; rd_en_i = 1; tick();
    end
    chk("udf after drain R7", 64'(udf_o), 64'd1);
    chk("empty after drain R7", 64'(empty_o), 64'd1);

    // R3: alternate elastic encoding 2'b11
    reset_to(2'b11, 1'b0);
    cur_req = "R3 alt";
    for (int i = 0; i < 20; i++) begin
      new_words(); wr_valid_i = (i % 3 == 0); rd_en_i = (i % 2 == 1); tick();
    end

    // R5: bypass register, read enable toggles and must be ignored
    reset_to(2'b01, 1'b0);
    cur_req = "R5";
    for (int i = 0; i < 20; i++) begin
      new_words(); wr_valid_i = (i % 3 != 2); rd_en_i = (i % 2 == 0); tick();
    end
    chk("bypass empty R5", 64'(empty_o), 64'd1);

    // R9: double width, fill past full in entries, then drain word by word
    reset_to(2'b10, 1'b1);
    cur_req = "R9 R6 R8";
    for (int i = 0; i < 18; i++) begin
      new_words(); wr_valid_i = 1; rd_en_i = 0; tick();
    end
    cur_req = "R9 R7 R10";
    for (int i = 0; i < 36; i++) begin
      new_words(); wr_valid_i = (i % 4 == 0); rd_en_i = 1; tick();
    end
    cur_req = "R9";
    for (int i = 0; i < 20; i++) begin
      new_words(); wr_valid_i = (i % 2 == 0); rd_en_i = (i % 3 != 0); tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule